// File: doc/BRIEF.md
# Double-Buffered Field Command Scheduler

This block arbitrates two command slots that sit side by side in memory and are read by a video coprocessor. The coprocessor fetches one command per vertical sync. The block keeps the two pointer registers the coprocessor looks at: the command now in use and the command to take at the next sync. When software commits a picture, the block picks a slot that neither pointer names. It writes that slot's per-field parameters and posts the slot's address as the next command. If no slot is free, the commit is refused with a busy pulse.

For interlaced pictures the commit describes the top field. The line pitches are doubled and the frame height is halved. The block also arms a bottom-pending flag. On the next top or bottom field event it builds the bottom-field command from the slot now in use. The new command is written to the free slot, with both plane addresses advanced by one source line, and is posted as next. If that build cannot find its slots, the field is skipped with an error pulse and the flag stays armed for the next event. A stop request parks the next pointer at zero.

The parameter outputs form a one-cycle write: the slot index, the field code, the two plane addresses, the two pitches and the height. The rest of the command payload is handled elsewhere.

Top module: `field_cmd_sched`

## Requirements
- R1: After reset both pointers are zero, the field count is zero, the bottom-pending flag is low, and no write or error pulse is given.
- R2: Slot n lies at slotBase + n*slotSize, for n = 0 or 1. A slot is free when its address equals neither curPtr nor nextPtr. When both slots are free, slot 0 is chosen.
- R3: A commit that finds a free slot gives, one cycle later, a write pulse to that slot and sets nextPtr to the slot's address. The field count increments by one. A progressive commit writes field code 1, the source pitches unchanged and the full source height, and it clears the bottom-pending flag.
- R4: An interlaced commit writes field code 2, both pitches doubled and the height halved (rounded down), and it sets the bottom-pending flag.
- R5: A commit that finds no free slot raises busyErr for one cycle. The pointers, field count and flag stay unchanged, and no write is given.
- R6: A top field event (evtKind 1) or bottom field event (evtKind 2) while the flag is set builds a copy of the slot that matches curPtr. The copy goes to the free slot with field code 0, the same pitches and height, and each plane address plus half of that plane's stored pitch. nextPtr takes the free slot's address, the count increments and the flag clears.
- R7: evtKind 0 and 3 never act. A field event while the flag is clear has no effect.
- R8: If a bottom-field build finds no free slot, or no slot equal to curPtr, skipErr pulses for one cycle. Nothing else changes, and the flag stays set.
- R9: On a fetch pulse, curPtr takes the value nextPtr held before that clock edge.
- R10: A stop request sets nextPtr to zero and clears the flag. In that cycle it overrides any commit or field event, and those are dropped.
- R11: When a commit and a field event arrive in the same cycle, only the commit is acted on. The event is dropped and cannot cause a skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| commitReq | input | 1 | Commit the source picture to a free slot |
| interlaced | input | 1 | The committed picture is interlaced |
| stopReq | input | 1 | Park the next pointer at zero |
| fetchPulse | input | 1 | Coprocessor takes the next command at a sync |
| evtKind | input | 2 | 0 none, 1 top field, 2 bottom field, 3 other |
| slotBase | input | ADDR_W | Address of slot 0 |
| slotSize | input | ADDR_W | Byte size of one slot |
| srcLumaAddr | input | ADDR_W | Luma plane address of the source |
| srcChromaAddr | input | ADDR_W | Chroma plane address of the source |
| srcLumaPitch | input | PITCH_W | Luma line pitch of the source |
| srcChromaPitch | input | PITCH_W | Chroma line pitch of the source |
| srcHeight | input | DIM_W | Source height in lines |
| curPtr | output | ADDR_W | Command in use by the coprocessor |
| nextPtr | output | ADDR_W | Command to fetch at the next sync |
| wrValid | output | 1 | Parameter write pulse |
| wrSlot | output | 1 | Slot being written |
| wrCfg | output | 2 | Field code: 0 bottom, 1 progressive, 2 top |
| wrLumaAddr | output | ADDR_W | Luma address written |
| wrChromaAddr | output | ADDR_W | Chroma address written |
| wrLumaPitch | output | PITCH_W+1 | Luma pitch written |
| wrChromaPitch | output | PITCH_W+1 | Chroma pitch written |
| wrHeight | output | DIM_W | Frame height written |
| busyErr | output | 1 | Commit refused, no free slot |
| skipErr | output | 1 | Bottom-field build skipped |
| fieldCount | output | CNT_W | Number of commands posted |
| btmPending | output | 1 | A bottom field is waiting to be built |

## Verification
The bench fills both slots: one pointer names each. It then checks that a third commit is refused and touches neither pointer. A design that compared only against nextPtr would overwrite the command the coprocessor is reading. It fires field events while curPtr names no slot, and while both slots are taken. A design that cleared the flag on a failed build would lose the bottom field for good. It also sends commits with odd heights and pitches, same-cycle commit and event, stop with commit, and unknown event codes. A design with the wrong half-pitch offset, the wrong priority or a wrong event decode shows up as a mismatch against the cycle model.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int SLOT_COUNT = 2;
  localparam int SLOT_IDX_W = 1;

  typedef enum logic [1:0] {
    CFG_BOTTOM = 2'd0,
    CFG_PROG   = 2'd1,
    CFG_TOP    = 2'd2
  } fieldCfg_e;

  typedef enum logic [1:0] {
    EVT_NONE   = 2'd0,
    EVT_TOP    = 2'd1,
    EVT_BOTTOM = 2'd2,
    EVT_OTHER  = 2'd3
  } evtKind_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic                  postCommit;
    logic                  postBottom;
    logic                  clearNext;
    logic                  interlaced;
    logic [SLOT_IDX_W-1:0] dstSlot;
    logic [SLOT_IDX_W-1:0] srcSlot;
  } fcsStrobe_t;
endpackage

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              commitReq,
  input  logic              interlaced,
  input  logic              stopReq,
  input  logic [1:0]        evtKind,
  input  logic [ADDR_W-1:0] slotBase,
  input  logic [ADDR_W-1:0] slotSize,
  input  logic [ADDR_W-1:0] curPtr,
  input  logic [ADDR_W-1:0] nextPtr,
  output fcsStrobe_t        strobe,
  output logic              busyErr,
  output logic              skipErr,
  output logic [CNT_W-1:0]  fieldCount,
  output logic              btmPending
);
  logic [SLOT_COUNT-1:0] freeVec;
  logic [SLOT_COUNT-1:0] curHit;
  logic [SLOT_IDX_W-1:0] freeIdx;
  logic [SLOT_IDX_W-1:0] curIdx;
  logic hasFree, hasCur, fieldEvt, doCommit, tryBottom;

  genvar g;
  generate
    for (g = 0; g < SLOT_COUNT; g++) begin : gSlot
      logic [ADDR_W-1:0] slotAddr;
      assign slotAddr   = slotBase + slotSize * ADDR_W'(g);
      assign freeVec[g] = (slotAddr != curPtr) && (slotAddr != nextPtr);
      assign curHit[g]  = (slotAddr == curPtr);
    end
  endgenerate

  // lowest index wins
  always_comb begin
    freeIdx = '0;
    curIdx  = '0;
    for (int i = SLOT_COUNT - 1; i >= 0; i--) begin
      if (freeVec[i]) freeIdx = SLOT_IDX_W'(i);
      if (curHit[i])  curIdx  = SLOT_IDX_W'(i);
    end
  end

  assign hasFree   = |freeVec;
  assign hasCur    = |curHit;
  assign fieldEvt  = (evtKind == EVT_TOP) || (evtKind == EVT_BOTTOM);
  assign doCommit  = !stopReq && commitReq;
  assign tryBottom = !stopReq && !commitReq && fieldEvt && btmPending;

  always_comb begin
    strobe.postCommit = doCommit && hasFree;
    strobe.postBottom = tryBottom && hasFree && hasCur;
    strobe.clearNext  = stopReq;
    strobe.interlaced = interlaced;
    strobe.dstSlot    = freeIdx;
    strobe.srcSlot    = curIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyErr    <= 1'b0;
      skipErr    <= 1'b0;
      fieldCount <= '0;
      btmPending <= 1'b0;
    end else begin
      busyErr <= doCommit && !hasFree;
      skipErr <= tryBottom && !(hasFree && hasCur);
      if (strobe.postCommit || strobe.postBottom)
        fieldCount <= fieldCount + 1'b1;
      if (stopReq)
        btmPending <= 1'b0;
      else if (strobe.postCommit)
        btmPending <= interlaced;
      else if (strobe.postBottom)
        btmPending <= 1'b0;
    end
  end
endmodule

// File: rtl/fcs_datapath.sv
module fcs_datapath
  import fcs_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PITCH_W = 16,
  parameter int DIM_W   = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fcsStrobe_t           strobe,
  input  logic                 fetchPulse,
  input  logic [ADDR_W-1:0]    slotBase,
  input  logic [ADDR_W-1:0]    slotSize,
  input  logic [ADDR_W-1:0]    srcLumaAddr,
  input  logic [ADDR_W-1:0]    srcChromaAddr,
  input  logic [PITCH_W-1:0]   srcLumaPitch,
  input  logic [PITCH_W-1:0]   srcChromaPitch,
  input  logic [DIM_W-1:0]     srcHeight,
  output logic [ADDR_W-1:0]    curPtr,
  output logic [ADDR_W-1:0]    nextPtr,
  output logic                 wrValid,
  output logic                 wrSlot,
  output logic [1:0]           wrCfg,
  output logic [ADDR_W-1:0]    wrLumaAddr,
  output logic [ADDR_W-1:0]    wrChromaAddr,
  output logic [PITCH_W:0]     wrLumaPitch,
  output logic [PITCH_W:0]     wrChromaPitch,
  output logic [DIM_W-1:0]     wrHeight
);
  localparam int SP_W = PITCH_W + 1;

  // per-slot copy of the fields a bottom build needs
  logic [ADDR_W-1:0] shLuma   [SLOT_COUNT];
  logic [ADDR_W-1:0] shChroma [SLOT_COUNT];
  logic [SP_W-1:0]   shLumaP  [SLOT_COUNT];
  logic [SP_W-1:0]   shChromaP[SLOT_COUNT];
  logic [DIM_W-1:0]  shHeight [SLOT_COUNT];

  logic [ADDR_W-1:0] newLuma, newChroma, dstAddr;
  logic [SP_W-1:0]   newLumaP, newChromaP;
  logic [DIM_W-1:0]  newHeight;
  logic [1:0]        newCfg;
  logic              doPost;

  assign doPost  = strobe.postCommit || strobe.postBottom;
  assign dstAddr = slotBase + (strobe.dstSlot[0] ? slotSize : '0);

  always_comb begin
    if (strobe.postCommit) begin
      newLuma   = srcLumaAddr;
      newChroma = srcChromaAddr;
      if (strobe.interlaced) begin
        newCfg     = CFG_TOP;
        newLumaP   = {srcLumaPitch, 1'b0};
        newChromaP = {srcChromaPitch, 1'b0};
        newHeight  = srcHeight >> 1;
      end else begin
        newCfg     = CFG_PROG;
        newLumaP   = {1'b0, srcLumaPitch};
        newChromaP = {1'b0, srcChromaPitch};
        newHeight  = srcHeight;
      end
    end else begin
      newCfg     = CFG_BOTTOM;
      newLumaP   = shLumaP[strobe.srcSlot];
      newChromaP = shChromaP[strobe.srcSlot];
      newHeight  = shHeight[strobe.srcSlot];
      newLuma    = shLuma[strobe.srcSlot]   + ADDR_W'(shLumaP[strobe.srcSlot] >> 1);
      newChroma  = shChroma[strobe.srcSlot] + ADDR_W'(shChromaP[strobe.srcSlot] >> 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPtr        <= '0;
      nextPtr       <= '0;
      wrValid       <= 1'b0;
      wrSlot        <= 1'b0;
      wrCfg         <= '0;
      wrLumaAddr    <= '0;
      wrChromaAddr  <= '0;
      wrLumaPitch   <= '0;
      wrChromaPitch <= '0;
      wrHeight      <= '0;
      for (int i = 0; i < SLOT_COUNT; i++) begin
        shLuma[i]    <= '0;
        shChroma[i]  <= '0;
        shLumaP[i]   <= '0;
        shChromaP[i] <= '0;
        shHeight[i]  <= '0;
      end
    end else begin
      wrValid <= 1'b0;
      if (fetchPulse) curPtr <= nextPtr;
      if (strobe.clearNext) begin
        nextPtr <= '0;
      end else if (doPost) begin
        nextPtr                   <= dstAddr;
        wrValid                   <= 1'b1;
        wrSlot                    <= strobe.dstSlot[0];
        wrCfg                     <= newCfg;
        wrLumaAddr                <= newLuma;
        wrChromaAddr              <= newChroma;
        wrLumaPitch               <= newLumaP;
        wrChromaPitch             <= newChromaP;
        wrHeight                  <= newHeight;
        shLuma[strobe.dstSlot]    <= newLuma;
        shChroma[strobe.dstSlot]  <= newChroma;
        shLumaP[strobe.dstSlot]   <= newLumaP;
        shChromaP[strobe.dstSlot] <= newChromaP;
        shHeight[strobe.dstSlot]  <= newHeight;
      end
    end
  end
endmodule

// File: rtl/field_cmd_sched.sv
module field_cmd_sched
  import fcs_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PITCH_W = 16,
  parameter int DIM_W   = 12,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               commitReq,
  input  logic               interlaced,
  input  logic               stopReq,
  input  logic               fetchPulse,
  input  logic [1:0]         evtKind,
  input  logic [ADDR_W-1:0]  slotBase,
  input  logic [ADDR_W-1:0]  slotSize,
  input  logic [ADDR_W-1:0]  srcLumaAddr,
  input  logic [ADDR_W-1:0]  srcChromaAddr,
  input  logic [PITCH_W-1:0] srcLumaPitch,
  input  logic [PITCH_W-1:0] srcChromaPitch,
  input  logic [DIM_W-1:0]   srcHeight,
  output logic [ADDR_W-1:0]  curPtr,
  output logic [ADDR_W-1:0]  nextPtr,
  output logic               wrValid,
  output logic               wrSlot,
  output logic [1:0]         wrCfg,
  output logic [ADDR_W-1:0]  wrLumaAddr,
  output logic [ADDR_W-1:0]  wrChromaAddr,
  output logic [PITCH_W:0]   wrLumaPitch,
  output logic [PITCH_W:0]   wrChromaPitch,
  output logic [DIM_W-1:0]   wrHeight,
  output logic               busyErr,
  output logic               skipErr,
  output logic [CNT_W-1:0]   fieldCount,
  output logic               btmPending
);
  fcsStrobe_t strobe;

  fcs_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .commitReq(commitReq), .interlaced(interlaced),
    .stopReq(stopReq), .evtKind(evtKind), .slotBase(slotBase),
    .slotSize(slotSize), .curPtr(curPtr), .nextPtr(nextPtr), .strobe(strobe),
    .busyErr(busyErr), .skipErr(skipErr), .fieldCount(fieldCount),
    .btmPending(btmPending)
  );

  fcs_datapath #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .DIM_W(DIM_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fetchPulse(fetchPulse),
    .slotBase(slotBase), .slotSize(slotSize), .srcLumaAddr(srcLumaAddr),
    .srcChromaAddr(srcChromaAddr), .srcLumaPitch(srcLumaPitch),
    .srcChromaPitch(srcChromaPitch), .srcHeight(srcHeight),
    .curPtr(curPtr), .nextPtr(nextPtr), .wrValid(wrValid), .wrSlot(wrSlot),
    .wrCfg(wrCfg), .wrLumaAddr(wrLumaAddr), .wrChromaAddr(wrChromaAddr),
    .wrLumaPitch(wrLumaPitch), .wrChromaPitch(wrChromaPitch),
    .wrHeight(wrHeight)
  );
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              stopReq,
  input logic              fetchPulse,
  input logic [ADDR_W-1:0] slotBase,
  input logic [ADDR_W-1:0] slotSize,
  input logic [ADDR_W-1:0] curPtr,
  input logic [ADDR_W-1:0] nextPtr,
  input logic              wrValid,
  input logic              wrSlot,
  input logic [1:0]        wrCfg,
  input logic              busyErr,
  input logic              skipErr,
  input logic              btmPending
);
  // R2/R3: a posted command points at the slot just written
  a_r3_post_at_slot: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> nextPtr == slotBase + (wrSlot ? slotSize : '0));

  // R4: a top-field command arms the bottom build
  a_r4_top_arms: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrCfg == 2'd2) |-> btmPending);

  // R6: a bottom command consumes the pending flag
  a_r6_btm_consumes: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrCfg == 2'd0) |-> (!btmPending && $past(btmPending)));

  // R5: a refused commit leaves next untouched
  a_r5_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    busyErr |-> (!wrValid && $stable(nextPtr)));

  // R8: a skipped build keeps the flag and next
  a_r8_skip_holds: assert property (@(posedge clk) disable iff (!rstN)
    skipErr |-> (btmPending && $stable(nextPtr)));

  // R5/R8: at most one outcome per cycle
  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrValid, busyErr, skipErr}));

  // R9: fetch moves next into current
  a_r9_fetch: assert property (@(posedge clk) disable iff (!rstN)
    fetchPulse |=> curPtr == $past(nextPtr));

  // R10: stop parks next and drops any post
  a_r10_stop: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> (nextPtr == '0 && !wrValid && !btmPending));
endmodule

bind field_cmd_sched fcs_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .stopReq(stopReq), .fetchPulse(fetchPulse),
  .slotBase(slotBase), .slotSize(slotSize), .curPtr(curPtr),
  .nextPtr(nextPtr), .wrValid(wrValid), .wrSlot(wrSlot), .wrCfg(wrCfg),
  .busyErr(busyErr), .skipErr(skipErr), .btmPending(btmPending)
);

// File: tb/field_cmd_sched_test.sv
`timescale 1ns/1ps
module field_cmd_sched_test;
  localparam int AW = 32, PW = 16, DW = 12, CW = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic commitReq = 0, interlaced = 0, stopReq = 0, fetchPulse = 0;
  logic [1:0] evtKind = 0;
  logic [AW-1:0] slotBase = 32'h1000, slotSize = 32'h200;
  logic [AW-1:0] srcLumaAddr = 32'h8000, srcChromaAddr = 32'h9000;
  logic [PW-1:0] srcLumaPitch = 16'h140, srcChromaPitch = 16'h140;
  logic [DW-1:0] srcHeight = 12'h1E1;
  logic [AW-1:0] curPtr, nextPtr, wrLumaAddr, wrChromaAddr;
  logic wrValid, wrSlot, busyErr, skipErr, btmPending;
  logic [1:0] wrCfg;
  logic [PW:0] wrLumaPitch, wrChromaPitch;
  logic [DW-1:0] wrHeight;
  logic [CW-1:0] fieldCount;

  always #4 clk = ~clk;

  field_cmd_sched #(.ADDR_W(AW), .PITCH_W(PW), .DIM_W(DW), .CNT_W(CW)) uut (.*);

  int total = 0, bad = 0;
  bit finished = 0;
  string curReq = "R1";

  // reference model state
  logic [AW-1:0] mCur, mNext;
  logic [AW-1:0] sL[2], sC[2];
  logic [PW:0] sLP[2], sCP[2];
  logic [DW-1:0] sH[2];
  logic [CW-1:0] mCnt;
  logic mPend, eWr, eBusy, eSkip, eSlot;
  logic [1:0] eCfg;
  logic [AW-1:0] eLA, eCA;
  logic [PW:0] eLP, eCP;
  logic [DW-1:0] eH;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic modelStep();
    logic [AW-1:0] a[2];
    logic fr[2], hit[2];
    logic [AW-1:0] newCur;
    int d, s;
    eWr = 0; eBusy = 0; eSkip = 0;
    if (!rstN) begin
      mCur = 0; mNext = 0; mCnt = 0; mPend = 0;
      for (int i = 0; i < 2; i++) begin sL[i]=0; sC[i]=0; sLP[i]=0; sCP[i]=0; sH[i]=0; end
      return;
    end
    a[0] = slotBase; a[1] = slotBase + slotSize;
    for (int i = 0; i < 2; i++) begin
      fr[i]  = (a[i] != mCur) && (a[i] != mNext);
      hit[i] = (a[i] == mCur);
    end
    d = fr[0] ? 0 : 1;
    s = hit[0] ? 0 : 1;
    newCur = fetchPulse ? mNext : mCur;
    if (stopReq) begin
      mNext = 0; mPend = 0;
    end else if (commitReq) begin
      if (fr[0] || fr[1]) begin
        eCfg = interlaced ? 2'd2 : 2'd1;
        eLP = interlaced ? {srcLumaPitch, 1'b0} : {1'b0, srcLumaPitch};
        eCP = interlaced ? {srcChromaPitch, 1'b0} : {1'b0, srcChromaPitch};
        eH = interlaced ? srcHeight / 2 : srcHeight;
        eLA = srcLumaAddr; eCA = srcChromaAddr;
        mPend = interlaced;
        eWr = 1;
      end else eBusy = 1;
    end else if ((evtKind == 2'd1 || evtKind == 2'd2) && mPend) begin
      if ((fr[0] || fr[1]) && (hit[0] || hit[1])) begin
        eCfg = 0; eLP = sLP[s]; eCP = sCP[s]; eH = sH[s];
        eLA = sL[s] + AW'(sLP[s] / 2); eCA = sC[s] + AW'(sCP[s] / 2);
        mPend = 0;
        eWr = 1;
      end else eSkip = 1;
    end
    if (eWr) begin
      eSlot = d[0];
      sL[d] = eLA; sC[d] = eCA; sLP[d] = eLP; sCP[d] = eCP; sH[d] = eH;
      mNext = a[d]; mCnt = mCnt + 1'b1;
    end
    mCur = newCur;
  endtask

  task automatic compareAll();
    check(curReq, "curPtr (R9)", curPtr, mCur);
    check(curReq, "nextPtr (R2)", nextPtr, mNext);
    check(curReq, "wrValid (R3)", wrValid, eWr);
    check(curReq, "busyErr (R5)", busyErr, eBusy);
    check(curReq, "skipErr (R8)", skipErr, eSkip);
    check(curReq, "fieldCount (R3)", fieldCount, mCnt);
    check(curReq, "btmPending (R4)", btmPending, mPend);
    if (eWr && wrValid) begin
      check(curReq, "wrSlot", wrSlot, eSlot);
      check(curReq, "wrCfg", wrCfg, eCfg);
      check(curReq, "wrLumaAddr", wrLumaAddr, eLA);
      check(curReq, "wrChromaAddr", wrChromaAddr, eCA);
      check(curReq, "wrLumaPitch", wrLumaPitch, eLP);
      check(curReq, "wrChromaPitch", wrChromaPitch, eCP);
      check(curReq, "wrHeight", wrHeight, eH);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
    commitReq = 0; stopReq = 0; fetchPulse = 0; evtKind = 0;
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    curReq = "R1";
    rstN = 0; tick(); tick();
    check("R1", "nextPtr after reset", nextPtr, 0);
    check("R1", "count after reset", fieldCount, 0);
    rstN = 1;
    tick();
    // R3: progressive commit to slot 0
    curReq = "R3";
    commitReq = 1; interlaced = 0; tick();
    check("R3", "nextPtr", nextPtr, 32'h1000);
    check("R3", "cfg", wrCfg, 1);
    check("R3", "height", wrHeight, 12'h1E1);
    curReq = "R9";
    fetchPulse = 1; tick();
    check("R9", "curPtr", curPtr, 32'h1000);
    curReq = "R2";
    commitReq = 1; tick();
    check("R2", "slot 1 chosen", nextPtr, 32'h1200);
    curReq = "R5";
    commitReq = 1; tick();
    check("R5", "busy", busyErr, 1);
    check("R5", "next held", nextPtr, 32'h1200);
    fetchPulse = 1; tick();
    curReq = "R4";
    commitReq = 1; interlaced = 1; tick();
    check("R4", "slot", wrSlot, 0);
    check("R4", "cfg", wrCfg, 2);
    check("R4", "pitch doubled", wrLumaPitch, 17'h280);
    check("R4", "height halved", wrHeight, 12'h0F0);
    check("R4", "pending", btmPending, 1);
    curReq = "R7";
    evtKind = 0; tick();
    evtKind = 3; tick();
    check("R7", "pending kept", btmPending, 1);
    curReq = "R8";
    evtKind = 1; tick();
    check("R8", "skip no free", skipErr, 1);
    check("R8", "pending kept", btmPending, 1);
    fetchPulse = 1; tick();
    curReq = "R6";
    evtKind = 2; tick();
    check("R6", "slot", wrSlot, 1);
    check("R6", "cfg", wrCfg, 0);
    check("R6", "luma", wrLumaAddr, 32'h8140);
    check("R6", "chroma", wrChromaAddr, 32'h9140);
    check("R6", "next", nextPtr, 32'h1200);
    check("R6", "count", fieldCount, 4);
    curReq = "R7";
    evtKind = 1; tick();
    check("R7", "no write", wrValid, 0);
    curReq = "R10";
    stopReq = 1; commitReq = 1; tick();
    check("R10", "next zero", nextPtr, 0);
    check("R10", "no write", wrValid, 0);
    curReq = "R11";
    commitReq = 1; interlaced = 1; tick();
    commitReq = 1; interlaced = 0; evtKind = 1; tick();
    check("R11", "busy", busyErr, 1);
    check("R11", "no skip", skipErr, 0);
    curReq = "R8";
    rstN = 0; tick(); rstN = 1; tick();
    commitReq = 1; interlaced = 1; srcHeight = 12'h0FF; srcLumaPitch = 16'h0FF; tick();
    evtKind = 1; tick();
    check("R8", "skip cur unmatched", skipErr, 1);
    // mixed traffic against the model
    curReq = "R6";
    for (int n = 0; n < 600; n++) begin
      commitReq = ($urandom_range(0, 3) == 0);
      interlaced = $urandom_range(0, 1);
      stopReq = ($urandom_range(0, 15) == 0);
      fetchPulse = ($urandom_range(0, 2) == 0);
      evtKind = 2'($urandom_range(0, 3));
      srcLumaAddr = $urandom; srcChromaAddr = $urandom;
      srcLumaPitch = 16'($urandom); srcChromaPitch = 16'($urandom);
      srcHeight = 12'($urandom);
      tick();
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule